// File: doc/BRIEF.md
# Direct-Mapped Cache with Swap-on-Hit Victim Buffer

This block is a direct-mapped first-level cache with a small fully associative buffer beside it. The buffer holds lines that were recently pushed out of the main array. Every request looks in the main array first. If that misses, the buffer is searched. When the buffer holds the block, the block moves into the main array, and the line it displaces there moves into the buffer slot the block just left. The request then completes without any traffic to the next level. Conflict misses between a few hot blocks that share an index are absorbed this way.

A request that misses in both places pushes the displaced main-array line into the buffer. This can push out an older buffer entry, and that entry goes to the next level only if it holds modified data. The requested block is then fetched from the next level into the main array. The cache is write-back with write-allocate. Refills and writebacks move a whole line in one beat. The CPU side is a request/acknowledge port that handles one word per request.

Top module: `vc_cache`

## Requirements
- R1: After reset, `cpu_ack`, `mem_req` and `wb_valid` are low. Every main-array line and buffer entry is invalid, so the first access to any address goes to the next level. The buffer replacement pointer starts at slot 0.
- R2: A request that hits the main array is acknowledged in the cycle right after the edge that accepts it. A load returns the stored word. A store replaces only the addressed word and marks the line modified.
- R3: A request that misses the main array but hits the buffer is acknowledged two cycles after acceptance, with no `mem_req` and no `wb_valid`. After it, the requested block sits in the main array and the previous main-array block (if valid) sits in that same buffer slot.
- R4: A request that misses in both places raises `mem_req` in the cycle after acceptance, with `mem_addr` set to the block address (word address bits above the offset). `mem_req` stays high until `mem_valid` is seen. The request is acknowledged in the cycle after `mem_valid`, and `mem_req` drops at the same time. In `mem_data`, word w of the line sits at bits [w*DW +: DW].
- R5: On a miss in both places, a valid main-array line at the index moves into the buffer, keeping its modified bit. If that line is invalid, the buffer is left unchanged.
- R6: The buffer slot that receives a moved line is the lowest-numbered invalid slot. When all slots are valid, it is the slot under a rotating pointer, and the pointer then advances by one, wrapping at the last slot.
- R7: A valid buffer entry that is displaced under R6 appears on `wb_valid` for exactly one cycle, in the same cycle `mem_req` rises, but only if its modified bit is set. `wb_addr` carries its block address and `wb_data` uses the same word layout as R4.
- R8: A block is held in at most one place (main array or one buffer slot), and its modified state travels with it through swaps and moves. Loads therefore always return the most recently stored value.
- R9: `cpu_ack` is a one-cycle pulse. A request is accepted only while the block is idle and `cpu_ack` is low. The word address splits into offset (low OFF_W bits), index (next IDX_W bits) and tag (the rest). `cpu_rdata` carries the addressed word as it stands after the operation, which for a store is the stored word.
- R10: The buffer is filled only by lines leaving the main array. A refilled block goes to the main array only, so the next access to it hits there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | Request valid, held until acknowledged |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | DW | Store data |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Addressed word after the operation |
| mem_req | output | 1 | Line fetch request to the next level |
| mem_addr | output | AW-OFF_W | Block address of the fetch |
| mem_valid | input | 1 | Fetched line present on mem_data |
| mem_data | input | DW*2^OFF_W | Fetched line |
| wb_valid | output | 1 | One-cycle pulse: modified line leaving the buffer |
| wb_addr | output | AW-OFF_W | Block address of the written-back line |
| wb_data | output | DW*2^OFF_W | Written-back line |

## Verification
The hardest case to reach is a modified line that gets pushed out of a full buffer. To get there, a store must first dirty a block. Several later conflicting misses at the same index must then carry that dirty block from the main array into the buffer and around the rotating pointer. Along the way, buffer hits keep moving blocks back and forth. The stimulus draws tags from a pool of six, so one index sees more distinct blocks than the main array and buffer can hold together, and about four in ten accesses are stores. A directed sequence at a single index walks through the fill-invalid-first order, the pointer wrap and the swap path. Load data is compared against a flat record of every store, so a lost or misplaced writeback shows up as a wrong word later on.

// File: rtl/vc_pkg.sv
package vc_pkg;

  // Controller phases of the cache.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SWAP = 2'd1,
    ST_FILL = 2'd2
  } vc_state_e;

endpackage

// File: rtl/vc_rst_sync.sv
module vc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/vc_l1_store.sv
module vc_l1_store #(
  parameter int unsigned TAG_W = 7,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned LW    = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_dirty,
  output logic [LW-1:0]    rd_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_dirty,
  input  logic [LW-1:0]    wr_data
);

  localparam int unsigned SETS = 1 << IDX_W;

  logic [SETS-1:0]  v_q, d_q;
  logic [TAG_W-1:0] tag_q  [SETS];
  logic [LW-1:0]    data_q [SETS];

  assign rd_valid = v_q[rd_idx];
  assign rd_dirty = d_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = data_q[rd_idx];

  // status bits carry a reset, payload does not
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      d_q <= '0;
    end else if (wr_en) begin
      v_q[wr_idx] <= wr_valid;
      d_q[wr_idx] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

endmodule

// File: rtl/vc_victim_buf.sv
module vc_victim_buf #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned BAW     = 10,
  parameter int unsigned LW      = 64,
  localparam int unsigned IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BAW-1:0]     lk_ba,
  output logic               hit,
  output logic [ENTRIES-1:0] hit_vec,
  output logic               hit_dirty,
  output logic [LW-1:0]      hit_data,
  output logic               sel_valid,
  output logic               sel_dirty,
  output logic [BAW-1:0]     sel_ba,
  output logic [LW-1:0]      sel_data,
  input  logic               ins_en,
  input  logic               swp_en,
  input  logic               wr_valid,
  input  logic [BAW-1:0]     wr_ba,
  input  logic               wr_dirty,
  input  logic [LW-1:0]      wr_data
);

  logic [ENTRIES-1:0] v_q, d_q;
  logic [BAW-1:0]     ba_q   [ENTRIES];
  logic [LW-1:0]      data_q [ENTRIES];
  logic [IW-1:0]      ptr_q, ptr_n;
  logic [IW-1:0]      hit_idx, sel_idx, wr_idx;
  logic               full, wr_en;

  // one comparator per slot
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = v_q[g] && (ba_q[g] == lk_ba);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) hit_idx = IW'(i);
    end
  end

  assign hit       = |hit_vec;
  assign hit_dirty = d_q[hit_idx];
  assign hit_data  = data_q[hit_idx];

  // lowest invalid slot first, rotating pointer when full
  assign full = &v_q;
  always_comb begin
    sel_idx = ptr_q;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!v_q[i]) sel_idx = IW'(i);
    end
  end

  assign sel_valid = v_q[sel_idx];
  assign sel_dirty = d_q[sel_idx];
  assign sel_ba    = ba_q[sel_idx];
  assign sel_data  = data_q[sel_idx];

  assign wr_en  = ins_en | swp_en;
  assign wr_idx = ins_en ? sel_idx : hit_idx;

  always_comb begin
    ptr_n = ptr_q;
    if (ins_en && full) ptr_n = (ptr_q == IW'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= '0;
      d_q   <= '0;
      ptr_q <= '0;
    end else begin
      ptr_q <= ptr_n;
      if (wr_en) begin
        v_q[wr_idx] <= wr_valid;
        d_q[wr_idx] <= wr_dirty;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ba_q[wr_idx]   <= wr_ba;
      data_q[wr_idx] <= wr_data;
    end
  end

endmodule

// File: rtl/vc_cache.sv
module vc_cache #(
  parameter int unsigned AW         = 12,
  parameter int unsigned DW         = 16,
  parameter int unsigned OFF_W      = 2,
  parameter int unsigned IDX_W      = 3,
  parameter int unsigned VC_ENTRIES = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cpu_req,
  input  logic                        cpu_we,
  input  logic [AW-1:0]               cpu_addr,
  input  logic [DW-1:0]               cpu_wdata,
  output logic                        cpu_ack,
  output logic [DW-1:0]               cpu_rdata,
  output logic                        mem_req,
  output logic [AW-OFF_W-1:0]         mem_addr,
  input  logic                        mem_valid,
  input  logic [DW*(1<<OFF_W)-1:0]    mem_data,
  output logic                        wb_valid,
  output logic [AW-OFF_W-1:0]         wb_addr,
  output logic [DW*(1<<OFF_W)-1:0]    wb_data
);

  import vc_pkg::*;

  localparam int unsigned WORDS = 1 << OFF_W;
  localparam int unsigned TAG_W = AW - OFF_W - IDX_W;
  localparam int unsigned BAW   = AW - OFF_W;
  localparam int unsigned LW    = DW * WORDS;

  logic rst_s;

  vc_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(rst_s));

  // ---------------- registers ----------------
  vc_state_e        state_q, state_n;
  logic             ack_q, ack_n;
  logic [DW-1:0]    rdata_q, rdata_n;
  logic             mreq_q, mreq_n;
  logic [BAW-1:0]   maddr_q, maddr_n;
  logic             wb_q, wb_n;
  logic [BAW-1:0]   wb_addr_q, wb_addr_n;
  logic [LW-1:0]    wb_data_q, wb_data_n;
  logic [AW-1:0]    q_addr;
  logic             q_we;
  logic [DW-1:0]    q_wdata;
  logic             ld_req;

  // ---------------- lookup address ----------------
  logic [AW-1:0]    lk_addr;
  logic             lk_we;
  logic [DW-1:0]    lk_wdata;
  logic [TAG_W-1:0] lk_tag;
  logic [IDX_W-1:0] lk_idx;
  logic [OFF_W-1:0] lk_off;
  logic [BAW-1:0]   lk_ba;

  assign lk_addr  = (state_q == ST_IDLE) ? cpu_addr  : q_addr;
  assign lk_we    = (state_q == ST_IDLE) ? cpu_we    : q_we;
  assign lk_wdata = (state_q == ST_IDLE) ? cpu_wdata : q_wdata;
  assign lk_tag   = lk_addr[AW-1 -: TAG_W];
  assign lk_idx   = lk_addr[OFF_W +: IDX_W];
  assign lk_off   = lk_addr[OFF_W-1:0];
  assign lk_ba    = lk_addr[AW-1:OFF_W];

  // ---------------- main array ----------------
  logic             l1_rd_valid, l1_rd_dirty;
  logic [TAG_W-1:0] l1_rd_tag;
  logic [LW-1:0]    l1_rd_data;
  logic             l1_we, l1_wvalid, l1_wdirty;
  logic [LW-1:0]    new_line;

  vc_l1_store #(.TAG_W(TAG_W), .IDX_W(IDX_W), .LW(LW)) u_l1 (
    .clk(clk), .rst_n(rst_s),
    .rd_idx(lk_idx), .rd_valid(l1_rd_valid), .rd_tag(l1_rd_tag),
    .rd_dirty(l1_rd_dirty), .rd_data(l1_rd_data),
    .wr_en(l1_we), .wr_idx(lk_idx), .wr_valid(l1_wvalid), .wr_tag(lk_tag),
    .wr_dirty(l1_wdirty), .wr_data(new_line)
  );

  // ---------------- victim buffer ----------------
  logic                  vc_hit, vc_hit_dirty, vc_sel_valid, vc_sel_dirty;
  logic [VC_ENTRIES-1:0] vc_hit_vec;
  logic [LW-1:0]         vc_hit_data, vc_sel_data;
  logic [BAW-1:0]        vc_sel_ba;
  logic                  vc_ins, vc_swp;

  // the line leaving the main array always feeds the buffer write port
  vc_victim_buf #(.ENTRIES(VC_ENTRIES), .BAW(BAW), .LW(LW)) u_vb (
    .clk(clk), .rst_n(rst_s), .lk_ba(lk_ba),
    .hit(vc_hit), .hit_vec(vc_hit_vec), .hit_dirty(vc_hit_dirty), .hit_data(vc_hit_data),
    .sel_valid(vc_sel_valid), .sel_dirty(vc_sel_dirty), .sel_ba(vc_sel_ba), .sel_data(vc_sel_data),
    .ins_en(vc_ins), .swp_en(vc_swp),
    .wr_valid(l1_rd_valid), .wr_ba({l1_rd_tag, lk_idx}),
    .wr_dirty(l1_rd_dirty), .wr_data(l1_rd_data)
  );

  // ---------------- datapath ----------------
  logic          accept, l1_hit;
  logic [LW-1:0] base_line;
  logic [DW-1:0] new_word;

  assign accept = (state_q == ST_IDLE) && cpu_req && !ack_q;
  assign l1_hit = l1_rd_valid && (l1_rd_tag == lk_tag);

  always_comb begin
    unique case (state_q)
      ST_SWAP: base_line = vc_hit_data;
      ST_FILL: base_line = mem_data;
      default: base_line = l1_rd_data;
    endcase
    new_line = base_line;
    if (lk_we) new_line[int'(lk_off)*DW +: DW] = lk_wdata;
  end

  assign new_word = new_line[int'(lk_off)*DW +: DW];

  // ---------------- next state ----------------
  always_comb begin
    state_n   = state_q;
    ack_n     = 1'b0;
    rdata_n   = rdata_q;
    mreq_n    = mreq_q;
    maddr_n   = maddr_q;
    wb_n      = 1'b0;
    wb_addr_n = wb_addr_q;
    wb_data_n = wb_data_q;
    ld_req    = 1'b0;
    l1_we     = 1'b0;
    l1_wvalid = 1'b1;
    l1_wdirty = 1'b0;
    vc_ins    = 1'b0;
    vc_swp    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          ld_req = 1'b1;
          if (l1_hit) begin
            l1_we     = lk_we;
            l1_wdirty = 1'b1;
            ack_n     = 1'b1;
            rdata_n   = new_word;
          end else if (vc_hit) begin
            state_n = ST_SWAP;
          end else begin
            vc_ins    = l1_rd_valid;
            wb_n      = l1_rd_valid && vc_sel_valid && vc_sel_dirty;
            wb_addr_n = vc_sel_ba;
            wb_data_n = vc_sel_data;
            l1_we     = 1'b1;
            l1_wvalid = 1'b0;
            mreq_n    = 1'b1;
            maddr_n   = lk_ba;
            state_n   = ST_FILL;
          end
        end
      end
      ST_SWAP: begin
        l1_we     = 1'b1;
        l1_wdirty = vc_hit_dirty | lk_we;
        vc_swp    = 1'b1;
        ack_n     = 1'b1;
        rdata_n   = new_word;
        state_n   = ST_IDLE;
      end
      ST_FILL: begin
        if (mem_valid) begin
          l1_we     = 1'b1;
          l1_wdirty = lk_we;
          mreq_n    = 1'b0;
          ack_n     = 1'b1;
          rdata_n   = new_word;
          state_n   = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= ST_IDLE;
      ack_q   <= 1'b0;
      mreq_q  <= 1'b0;
      wb_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      ack_q   <= ack_n;
      mreq_q  <= mreq_n;
      wb_q    <= wb_n;
    end
  end

  always_ff @(posedge clk) begin
    rdata_q   <= rdata_n;
    maddr_q   <= maddr_n;
    wb_addr_q <= wb_addr_n;
    wb_data_q <= wb_data_n;
    if (ld_req) begin
      q_addr  <= cpu_addr;
      q_we    <= cpu_we;
      q_wdata <= cpu_wdata;
    end
  end

  assign cpu_ack   = ack_q;
  assign cpu_rdata = rdata_q;
  assign mem_req   = mreq_q;
  assign mem_addr  = maddr_q;
  assign wb_valid  = wb_q;
  assign wb_addr   = wb_addr_q;
  assign wb_data   = wb_data_q;

endmodule

// File: rtl/vc_cache_chk.sv
module vc_cache_chk
  import vc_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input logic      clk,
  input logic      rst_n,
  input vc_state_e state_q,
  input logic      accept,
  input logic      l1_hit,
  input logic      vc_hit,
  input logic [N-1:0] vc_hit_vec,
  input logic      cpu_ack,
  input logic      mem_req,
  input logic      mem_valid,
  input logic      wb_valid
);

  // R9
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack);

  // R2
  l1_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && l1_hit) |=> cpu_ack);

  // R3
  vc_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !l1_hit && vc_hit) |=> (state_q == ST_SWAP) && !cpu_ack && !mem_req);

  // R3
  vc_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SWAP) |=> cpu_ack && !mem_req);

  // R4
  mreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> mem_req);

  // R4
  fill_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_valid) |=> cpu_ack && !mem_req);

  // R7
  wb_rose_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $rose(mem_req));

  // R8
  vc_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vc_hit_vec));

  // R8
  one_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(l1_hit && vc_hit));

endmodule

bind vc_cache vc_cache_chk #(.N(VC_ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_s), .state_q(state_q), .accept(accept),
  .l1_hit(l1_hit), .vc_hit(vc_hit), .vc_hit_vec(vc_hit_vec),
  .cpu_ack(cpu_ack), .mem_req(mem_req), .mem_valid(mem_valid), .wb_valid(wb_valid)
);

// File: tb/vc_cache_test.sv
module vc_cache_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req, cpu_we;
  logic [11:0] cpu_addr;
  logic [15:0] cpu_wdata;
  logic        cpu_ack;
  logic [15:0] cpu_rdata;
  logic        mem_req;
  logic [9:0]  mem_addr;
  logic        mem_valid;
  logic [63:0] mem_data;
  logic        wb_valid;
  logic [9:0]  wb_addr;
  logic [63:0] wb_data;

  vc_cache uut (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;

  // golden word values and next-level contents
  logic [15:0] gold [4096];
  logic [15:0] nxt  [4096];

  // requirement-level model of placement
  logic       m_v [8];
  logic [6:0] m_tag [8];
  logic       m_d [8];
  logic       c_v [4];
  logic [9:0] c_ba [4];
  logic       c_d [4];
  int         c_ptr;

  int         wb_cnt;
  logic [9:0] wb_last;
  int         req_cnt;
  logic [9:0] req_last;

  function automatic logic [15:0] initv(int a);
    return 16'((a * 40503 + 17) ^ (a >> 3));
  endfunction

  task automatic check(bit ok, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", what, act, exp);
    end
  endtask

  // next level: answer each line request after 1..3 cycles
  initial begin
    mem_valid = 1'b0;
    mem_data  = '0;
    req_cnt   = 0;
    forever begin
      @(negedge clk);
      if (mem_req && !mem_valid) begin
        int d;
        req_cnt++;
        req_last = mem_addr;
        d = 1 + int'($urandom % 3);
        repeat (d) @(negedge clk);
        for (int w = 0; w < 4; w++) mem_data[w*16 +: 16] = nxt[{mem_addr, 2'(w)}];
        mem_valid = 1'b1;
        @(negedge clk);
        mem_valid = 1'b0;
      end
    end
  end

  // writeback sink (R7 layout: word w at bits w*16)
  initial begin
    wb_cnt = 0;
    forever begin
      @(negedge clk);
      if (wb_valid) begin
        for (int w = 0; w < 4; w++) nxt[{wb_addr, 2'(w)}] = wb_data[w*16 +: 16];
        wb_cnt++;
        wb_last = wb_addr;
      end
    end
  end

  task automatic access(logic [11:0] a, bit we, logic [15:0] wd, string ctx);
    logic [2:0] idx = a[4:2];
    logic [6:0] tag = a[11:5];
    logic [9:0] ba  = a[11:2];
    int cls, s, sl, cyc, wb0, rq0;
    bit full, exp_wb, ov, od;
    logic [9:0] exp_wba;
    logic [6:0] ot;
    logic [15:0] rd;
    s = -1; sl = -1; full = 0; exp_wb = 0; exp_wba = '0;
    if (m_v[idx] && m_tag[idx] == tag) cls = 1;
    else begin
      for (int i = 0; i < 4; i++) if (c_v[i] && c_ba[i] == ba) s = i;
      cls = (s >= 0) ? 2 : 3;
    end
    if (cls == 3 && m_v[idx]) begin
      for (int i = 0; i < 4; i++) if (!c_v[i] && sl < 0) sl = i;
      if (sl < 0) begin full = 1; sl = c_ptr; end
      exp_wb  = c_v[sl] && c_d[sl];
      exp_wba = c_ba[sl];
    end
    wb0 = wb_cnt; rq0 = req_cnt;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_ack && cyc < 50);
    rd = cpu_rdata;
    cpu_req = 1'b0;
    if (we) gold[a] = wd;
    // R9 rdata is the word after the operation; R8 latest value
    check(rd == gold[a], $sformatf("R8/R9 %s data addr=%0h", ctx, a), 64'(rd), 64'(gold[a]));
    if (cls == 1)
      check(cyc == 1, $sformatf("R2 %s main-array hit latency", ctx), 64'(cyc), 64'd1);
    else if (cls == 2) begin
      check(cyc == 2, $sformatf("R3 %s buffer hit latency", ctx), 64'(cyc), 64'd2);
      check(req_cnt == rq0, $sformatf("R3 %s no fetch on buffer hit", ctx), 64'(req_cnt - rq0), 64'd0);
    end else begin
      check(cyc >= 3 && cyc < 50, $sformatf("R4 %s miss latency", ctx), 64'(cyc), 64'd3);
      check(req_cnt == rq0 + 1 && req_last == ba, $sformatf("R4 %s fetch address", ctx),
            64'(req_last), 64'(ba));
    end
    check(wb_cnt - wb0 == int'(exp_wb), $sformatf("R7 %s writeback count", ctx),
          64'(wb_cnt - wb0), 64'(exp_wb));
    if (exp_wb && wb_cnt != wb0)
      check(wb_last == exp_wba, $sformatf("R6/R7 %s writeback address", ctx), 64'(wb_last), 64'(exp_wba));
    // model update per R3, R5, R6, R10
    if (cls == 1) begin
      if (we) m_d[idx] = 1'b1;
    end else if (cls == 2) begin
      ov = m_v[idx]; ot = m_tag[idx]; od = m_d[idx];
      m_v[idx] = 1'b1; m_tag[idx] = tag; m_d[idx] = c_d[s] | we;
      c_v[s] = ov; c_ba[s] = {ot, idx}; c_d[s] = od;
    end else begin
      if (m_v[idx]) begin
        c_v[sl] = 1'b1; c_ba[sl] = {m_tag[idx], idx}; c_d[sl] = m_d[idx];
        if (full) c_ptr = (c_ptr + 1) % 4;
      end
      m_v[idx] = 1'b1; m_tag[idx] = tag; m_d[idx] = we;
    end
    @(negedge clk);
    check(!cpu_ack, $sformatf("R9 %s ack is one cycle", ctx), 64'(cpu_ack), 64'd0);
  endtask

  function automatic logic [11:0] mk(int t, int i, int o);
    return {7'(t), 3'(i), 2'(o)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_0042);
    for (int i = 0; i < 4096; i++) begin gold[i] = initv(i); nxt[i] = initv(i); end
    for (int i = 0; i < 8; i++) begin m_v[i] = 0; m_d[i] = 0; m_tag[i] = '0; end
    for (int i = 0; i < 4; i++) begin c_v[i] = 0; c_d[i] = 0; c_ba[i] = '0; end
    c_ptr = 0;
    cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!cpu_ack && !mem_req && !wb_valid, "R1 outputs idle in reset",
          64'({cpu_ack, mem_req, wb_valid}), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!cpu_ack && !mem_req && !wb_valid, "R1 outputs idle after reset",
          64'({cpu_ack, mem_req, wb_valid}), 64'd0);

    // R1: first access misses; R10: then hits the main array
    access(mk(1, 0, 1), 0, '0, "R1 cold");
    access(mk(1, 0, 2), 1, 16'hA1A1, "R10 refilled block");
    // R5/R6: fill buffer slots 0..3 in order from index 0 conflicts
    for (int t = 2; t <= 5; t++) access(mk(t, 0, t % 4), (t == 3), 16'h3000 + 16'(t), "R5 R6 fill");
    // R6/R7: buffer full, pointer displaces slot 0 (dirty tag1 block)
    access(mk(6, 0, 0), 0, '0, "R6 pointer wrap");
    // R3: swap back a buffered block, then old resident hits buffer
    access(mk(3, 0, 3), 0, '0, "R3 swap");
    access(mk(6, 0, 0), 1, 16'hBEEF, "R3 swap back");
    access(mk(6, 0, 0), 0, '0, "R2 after swap");
    access(mk(1, 0, 2), 0, '0, "R7 refetch written-back");

    // mixed random traffic with a small tag pool
    for (int n = 0; n < 1500; n++) begin
      int t = int'($urandom % 6);
      int i = int'($urandom % 4);
      int o = int'($urandom % 4);
      bit w = ($urandom % 10) < 4;
      access(mk(t, i, o), w, 16'($urandom), "random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule